// File: doc/BRIEF.md
# Parallel ADC Capture Serializer

This block sits in front of a multichannel decimating filter that accepts one channel sample per clock. An ADC delivers all of its channels at once, together with a one-cycle data-ready strobe. The serializer captures that parallel word into a shift register and then presents it as a stream of beats, one channel per clock in channel order. Each beat carries streaming valid, start-of-packet and end-of-packet flags. The flags are written into each register step at load time, so they shift out together with the data, and zeroed steps follow behind them.

On the return side the filter's result stream (data, valid, channel, start and end markers) passes through unchanged. The filter's error output is dropped. The error code sent toward the filter is held at zero, and the ready signal returned to the filter output is held high. The channel count is a parameter and is normally 4 or 2. A strobe that arrives while a packet is still shifting out wins: it reloads the register at once.

Top module: `adc_stream_serializer`

## Requirements
- R1: While reset is asserted, and until the first strobe after it, `snk_valid_o`, `snk_sop_o` and `snk_eop_o` are 0 and `snk_data_o` is 0.
- R2: In the cycle after a clock edge that samples `cap_strobe_i` high, the outputs present channel 0, taken from `cap_data_i[15:0]`, with `snk_valid_o`=1 and `snk_sop_o`=1.
- R3: Beat k (k = 0..NUM_CH-1) of a packet appears k cycles after beat 0 and carries channel k, taken from `cap_data_i[16k+15:16k]` as it was at the loading edge, with `snk_valid_o`=1. The beats come in consecutive cycles.
- R4: `snk_sop_o` is 1 only on beat 0 and `snk_eop_o` is 1 only on beat NUM_CH-1.
- R5: If no new strobe arrives, the cycle after the end-of-packet beat and every later one show valid, SOP and EOP at 0 and data at 0.
- R6: A strobe sampled while a packet is still shifting reloads the register. The next cycle shows beat 0 of the new capture, and the rest of the old packet is dropped.
- R7: If strobes are spaced exactly NUM_CH cycles apart, every captured sample is delivered, NUM_CH valid beats per strobe.
- R8: `snk_err_o` is always 2'b00.
- R9: `flt_ready_o` is always 1.
- R10: `res_data_o`, `res_valid_o`, `res_chan_o`, `res_sop_o` and `res_eop_o` equal `flt_data_i`, `flt_valid_i`, `flt_chan_i`, `flt_sop_i` and `flt_eop_i` in the same cycle.
- R11: `flt_err_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_strobe_i | input | 1 | Data-ready strobe for a parallel capture |
| cap_data_i | input | NUM_CH*16 | Parallel samples, channel k at bits 16k+15:16k |
| snk_data_o | output | 16 | Serialized sample toward the filter |
| snk_valid_o | output | 1 | Beat valid |
| snk_sop_o | output | 1 | First beat of a packet |
| snk_eop_o | output | 1 | Last beat of a packet |
| snk_err_o | output | 2 | Error code toward the filter, held at 0 |
| flt_data_i | input | RES_W | Filter result data |
| flt_valid_i | input | 1 | Filter result valid |
| flt_chan_i | input | CH_W | Filter result channel index |
| flt_sop_i | input | 1 | Filter result start marker |
| flt_eop_i | input | 1 | Filter result end marker |
| flt_err_i | input | 2 | Filter error code, ignored |
| flt_ready_o | output | 1 | Ready to the filter output, held at 1 |
| res_data_o | output | RES_W | Passed-through result data |
| res_valid_o | output | 1 | Passed-through valid |
| res_chan_o | output | CH_W | Passed-through channel |
| res_sop_o | output | 1 | Passed-through start marker |
| res_eop_o | output | 1 | Passed-through end marker |

## Verification
The hardest case to reach is a reload in the middle of a packet. The strobe must land while the register still holds beats of an earlier capture, and the bench must show that those beats never appear. A directed sequence places a strobe exactly on the second beat. The random phase then fires strobes about one cycle in three, so reloads land on every beat position, including the end-of-packet beat. Back-to-back captures at the minimum spacing are also driven on purpose, to show that no beat is lost at the packet boundary.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  parameter int SAMPLE_W = 16;

  typedef struct packed {
    logic                eop;
    logic                sop;
    logic                valid;
    logic [SAMPLE_W-1:0] data;
  } step_t;
endpackage

// File: rtl/ser_load_image.sv
module ser_load_image
  import adc_ser_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
  output step_t [NUM_CH-1:0]         image_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_step
    always_comb begin
      image_o[k].data  = samples_i[k*SAMPLE_W +: SAMPLE_W];
      image_o[k].valid = 1'b1;
      image_o[k].sop   = (k == 0);
      image_o[k].eop   = (k == NUM_CH - 1);
    end
  end
endmodule

// File: rtl/ser_shift_chain.sv
module ser_shift_chain
  import adc_ser_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  step_t [NUM_CH-1:0]  image_i,
  output step_t               head_o
);
  step_t [NUM_CH-1:0] q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_stage
    step_t nxt;
    if (k == NUM_CH - 1) begin : g_tail
      assign nxt = load_i ? image_i[k] : '0;
    end else begin : g_mid
      assign nxt = load_i ? image_i[k] : q[k+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[k] <= '0;
      else         q[k] <= nxt;
    end
  end

  assign head_o = q[0];
endmodule

// File: rtl/ser_result_pass.sv
module ser_result_pass #(
  parameter int RES_W = 28,
  parameter int CH_W  = 2
) (
  input  logic [RES_W-1:0] flt_data_i,
  input  logic             flt_valid_i,
  input  logic [CH_W-1:0]  flt_chan_i,
  input  logic             flt_sop_i,
  input  logic             flt_eop_i,
  output logic             flt_ready_o,
  output logic [1:0]       snk_err_o,
  output logic [RES_W-1:0] res_data_o,
  output logic             res_valid_o,
  output logic [CH_W-1:0]  res_chan_o,
  output logic             res_sop_o,
  output logic             res_eop_o
);
  assign flt_ready_o = 1'b1;
  assign snk_err_o   = 2'b00;
  assign res_data_o  = flt_data_i;
  assign res_valid_o = flt_valid_i;
  assign res_chan_o  = flt_chan_i;
  assign res_sop_o   = flt_sop_i;
  assign res_eop_o   = flt_eop_i;
endmodule

// File: rtl/adc_stream_serializer.sv
module adc_stream_serializer
  import adc_ser_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 28,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cap_strobe_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] cap_data_i,
  output logic [SAMPLE_W-1:0]        snk_data_o,
  output logic                       snk_valid_o,
  output logic                       snk_sop_o,
  output logic                       snk_eop_o,
  output logic [1:0]                 snk_err_o,
  input  logic [RES_W-1:0]           flt_data_i,
  input  logic                       flt_valid_i,
  input  logic [CH_W-1:0]            flt_chan_i,
  input  logic                       flt_sop_i,
  input  logic                       flt_eop_i,
  input  logic [1:0]                 flt_err_i,
  output logic                       flt_ready_o,
  output logic [RES_W-1:0]           res_data_o,
  output logic                       res_valid_o,
  output logic [CH_W-1:0]            res_chan_o,
  output logic                       res_sop_o,
  output logic                       res_eop_o
);
  step_t [NUM_CH-1:0] image;
  step_t              head;
  logic [1:0]         err_unused;

  assign err_unused = flt_err_i;  // filter error carries nothing useful

  ser_load_image #(.NUM_CH(NUM_CH)) u_image (
    .samples_i (cap_data_i),
    .image_o   (image)
  );

  ser_shift_chain #(.NUM_CH(NUM_CH)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cap_strobe_i),
    .image_i (image),
    .head_o  (head)
  );

  assign snk_data_o  = head.data;
  assign snk_valid_o = head.valid;
  assign snk_sop_o   = head.sop;
  assign snk_eop_o   = head.eop;

  ser_result_pass #(.RES_W(RES_W), .CH_W(CH_W)) u_pass (
    .flt_data_i  (flt_data_i),
    .flt_valid_i (flt_valid_i),
    .flt_chan_i  (flt_chan_i),
    .flt_sop_i   (flt_sop_i),
    .flt_eop_i   (flt_eop_i),
    .flt_ready_o (flt_ready_o),
    .snk_err_o   (snk_err_o),
    .res_data_o  (res_data_o),
    .res_valid_o (res_valid_o),
    .res_chan_o  (res_chan_o),
    .res_sop_o   (res_sop_o),
    .res_eop_o   (res_eop_o)
  );
endmodule

// File: rtl/ser_checker.sv
module ser_checker
  import adc_ser_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cap_strobe_i,
  input logic [SAMPLE_W-1:0] snk_data_o,
  input logic                snk_valid_o,
  input logic                snk_sop_o,
  input logic                snk_eop_o
);
  AST_LOAD_OPENS_PACKET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_strobe_i |=> snk_valid_o && snk_sop_o && !snk_eop_o); // R2
  AST_BEATS_CONTIGUOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_valid_o && !snk_eop_o && !cap_strobe_i |=> snk_valid_o && !snk_sop_o); // R3
  AST_SOP_EOP_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snk_sop_o && snk_eop_o)); // R4
  AST_EOP_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_eop_o && !cap_strobe_i |=> !snk_valid_o); // R5
  AST_IDLE_ZEROED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snk_valid_o |-> snk_data_o == '0 && !snk_sop_o && !snk_eop_o); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snk_valid_o && !cap_strobe_i |=> !snk_valid_o); // R5
endmodule

bind adc_stream_serializer ser_checker u_ser_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cap_strobe_i (cap_strobe_i),
  .snk_data_o   (snk_data_o),
  .snk_valid_o  (snk_valid_o),
  .snk_sop_o    (snk_sop_o),
  .snk_eop_o    (snk_eop_o)
);

// File: tb/tb_adc_stream_serializer.sv
module tb_adc_stream_serializer;
  localparam int N  = 4;
  localparam int SW = 16;
  localparam int RW = 28;
  localparam int CW = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic          cap_strobe_i = 1'b0;
  logic [N*SW-1:0] cap_data_i = '0;
  logic [SW-1:0] snk_data_o;
  logic          snk_valid_o, snk_sop_o, snk_eop_o;
  logic [1:0]    snk_err_o;
  logic [RW-1:0] flt_data_i = '0;
  logic          flt_valid_i = 1'b0;
  logic [CW-1:0] flt_chan_i = '0;
  logic          flt_sop_i = 1'b0, flt_eop_i = 1'b0;
  logic [1:0]    flt_err_i = '0;
  logic          flt_ready_o;
  logic [RW-1:0] res_data_o;
  logic          res_valid_o, res_sop_o, res_eop_o;
  logic [CW-1:0] res_chan_o;

  adc_stream_serializer #(.NUM_CH(N), .RES_W(RW)) dut (.*);

  int checks = 0, errors = 0, beat_cnt = 0;

  // expected state, from the requirements
  logic [SW-1:0] m_lat [N];
  int  m_idx;
  bit  m_act;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act <= 1'b0; m_idx <= 0;
    end else if (cap_strobe_i) begin
      for (int k = 0; k < N; k++) m_lat[k] <= cap_data_i[k*SW +: SW];
      m_idx <= 0; m_act <= 1'b1;
    end else if (m_act) begin
      if (m_idx == N-1) m_act <= 1'b0;
      else m_idx <= m_idx + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_stream();
    if (snk_valid_o === 1'b1) beat_cnt++;
    if (m_act) begin
      chk(m_idx == 0 ? "R2 data" : "R3 data", 64'(snk_data_o), 64'(m_lat[m_idx]));
      chk("R3 valid", 64'(snk_valid_o), 64'd1);
      chk("R4 sop", 64'(snk_sop_o), 64'(m_idx == 0));
      chk("R4 eop", 64'(snk_eop_o), 64'(m_idx == N-1));
    end else begin
      chk("R5 idle", {snk_valid_o, snk_sop_o, snk_eop_o, snk_data_o}, '0);
    end
    chk("R8 err", 64'(snk_err_o), 64'd0);
    chk("R9 ready", 64'(flt_ready_o), 64'd1);
    chk("R10 pass", {res_data_o, res_valid_o, res_chan_o, res_sop_o, res_eop_o},
        {flt_data_i, flt_valid_i, flt_chan_i, flt_sop_i, flt_eop_i});
  endtask

  function automatic logic [N*SW-1:0] rnd_cap();
    logic [N*SW-1:0] v;
    for (int k = 0; k < N; k++) v[k*SW +: SW] = SW'($urandom);
    return v;
  endfunction

  task automatic cyc(input bit strobe, input logic [N*SW-1:0] d);
    @(negedge clk_i);
    check_stream();
    cap_strobe_i = strobe;
    cap_data_i   = d;
    flt_data_i   = RW'($urandom);
    flt_valid_i  = 1'($urandom);
    flt_chan_i   = CW'($urandom);
    flt_sop_i    = 1'($urandom);
    flt_eop_i    = 1'($urandom);
    flt_err_i    = 2'($urandom);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N*SW-1:0] a, b;
    logic [RW+CW+3+SW+7:0] snap;
    void'($urandom(32'h5eed_0042));
    // R1: reset state
    repeat (2) begin
      @(negedge clk_i);
      chk("R1 reset", {snk_valid_o, snk_sop_o, snk_eop_o, snk_data_o}, '0);
    end
    rst_ni = 1'b1;
    repeat (3) cyc(0, rnd_cap());
    chk("R1 after reset", {snk_valid_o, snk_sop_o, snk_eop_o, snk_data_o}, '0);

    // single packet, idle tail (R2 R3 R4 R5)
    cyc(1, 64'h4444_3333_2222_1111);
    repeat (N + 3) cyc(0, rnd_cap());

    // R6: reload on beat 1
    a = rnd_cap(); b = rnd_cap();
    cyc(1, a);
    cyc(0, rnd_cap());
    cyc(1, b);
    cyc(0, rnd_cap());
    chk("R6 reload data", 64'(snk_data_o), 64'(b[SW-1:0]));
    chk("R6 reload sop", 64'(snk_sop_o), 64'd1);
    repeat (N + 2) cyc(0, rnd_cap());

    // R7: strobes exactly N apart
    beat_cnt = 0;
    for (int p = 0; p < 8; p++) begin
      cyc(1, rnd_cap());
      repeat (N - 1) cyc(0, rnd_cap());
    end
    repeat (N + 2) cyc(0, rnd_cap());
    chk("R7 beat count", 64'(beat_cnt), 64'(8 * N));

    // R11: error input has no effect
    for (int t = 0; t < 6; t++) begin
      cyc(t == 0, rnd_cap());
      #1;
      snap = {snk_data_o, snk_valid_o, snk_sop_o, snk_eop_o, snk_err_o, flt_ready_o,
              res_data_o, res_valid_o, res_chan_o, res_sop_o, res_eop_o};
      flt_err_i = ~flt_err_i;
      #1;
      chk("R11 err ignored", 64'({snk_data_o, snk_valid_o, snk_sop_o, snk_eop_o, snk_err_o,
          flt_ready_o, res_data_o, res_valid_o, res_chan_o, res_sop_o, res_eop_o}), 64'(snap));
    end

    // random mix, reloads at any beat position
    for (int i = 0; i < 3000; i++) cyc(($urandom % 3) == 0, rnd_cap());
    repeat (N + 2) cyc(0, rnd_cap());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule